// File: doc/BRIEF.md
# LPC host cycle generator

This block is the host side of a Low Pin Count bus. A local requester presents one transfer at a time: the kind of cycle (I/O, memory, firmware or DMA), the direction, an address or a DMA channel with its terminal-count flag, a size, and the write data. The block then owns the 4-bit LAD bus and the active-low frame strobe. It walks the nibble sequence that fits the cycle kind, hands the bus to the peripheral through turnarounds, waits through any number of wait-sync nibbles, collects read data, and returns the bus to the host.

When the sequence ends, the block pulses an acknowledge for one clock. With that pulse it returns the assembled read data, a fault flag for an error sync and a timeout flag. If a peripheral keeps answering with wait codes for too long, the block aborts the cycle on the bus itself. The pad tristate is left to the surrounding logic: the block only gives an output enable next to its output nibble.

Top module: `lpc_host_cycle_gen`

## Requirements
- R1: Out of reset, `frame_n` is 1, `lad_oe` is 0 and `req_ack` is 0.
- R2: The first bus clock of a cycle has `frame_n` low and LAD driven with the start nibble. That nibble is 0000 for I/O, memory and DMA, 1101 for a firmware read and 1110 for a firmware write. `frame_n` stays low for that single clock only.
- R3: Cycles other than firmware send a type nibble after the start nibble. Bit 3 is set for DMA and bit 2 for memory. Bit 1 is the direction: set for a write on I/O or memory, and set for a DMA read. Bit 0 is zero.
- R4: An I/O cycle sends `req_addr[15:0]` as 4 nibbles and a memory or firmware cycle sends `req_addr[31:0]` as 8 nibbles, with the most significant nibble first.
- R5: A DMA cycle sends no address. It sends `{req_dma_tc, req_dma_chan}` and then a size nibble of 0, 1 or 3. A firmware cycle sends a size nibble of 0, 1 or 2 after its address. `req_size` 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 select 4 bytes. I/O and memory cycles always move one byte.
- R6: Data moves least significant nibble first and lowest byte first, in both directions. Bytes beyond the size read back as zero in `rsp_rdata`, and `rsp_rdata` is zero after a write.
- R7: Bus ownership changes through two clocks. When the host releases the bus it drives 1111 with `lad_oe` high and then floats. When the peripheral releases it, the host keeps `lad_oe` low for two clocks.
- R8: In a sync clock, 0000 means ready and the cycle goes on. 0101, 0110 and any code not named here count as wait, and the host keeps sampling.
- R9: An error sync of 1010 is followed by a two-clock turnaround. The cycle then ends with `rsp_err` set.
- R10: After `TMO_CLKS` sync clocks with no ready or error code, the host drives `frame_n` low with 1111 on LAD for 4 clocks. The acknowledge that follows carries `rsp_timeout` set.
- R11: A DMA cycle repeats the sync for every byte. For a DMA read, each ready sync is followed by that byte. For a DMA write, each byte gets its own data, turnaround, sync and turnaround.
- R12: `req_ack` is high for exactly one clock, in the clock after the last bus clock. `req_valid` is taken only when the block is idle: a request raised during a cycle changes nothing and starts no cycle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_kind | input | 2 | 0 I/O, 1 memory, 2 firmware, 3 DMA |
| req_write | input | 1 | 1 = host sends data to the peripheral |
| req_addr | input | 32 | Cycle address |
| req_size | input | 2 | 0 one byte, 1 two bytes, 2 or 3 four bytes |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| req_dma_tc | input | 1 | DMA terminal-count flag |
| req_dma_chan | input | 3 | DMA channel number |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Read data, valid with req_ack |
| rsp_err | output | 1 | Error sync was received |
| rsp_timeout | output | 1 | Cycle was aborted for lack of sync |
| frame_n | output | 1 | Frame strobe, active low |
| lad_out | output | 4 | LAD nibble driven by the host |
| lad_oe | output | 1 | LAD output enable |
| lad_in | input | 4 | LAD nibble seen on the bus |

## Verification
A bench peripheral follows every bus clock against a trace built from the request. It is tried with each cycle kind in both directions and with every size, which separates the four nibble sequences, the two size encodings and the per-byte DMA loop from the grouped transfer. Address and data patterns with distinct nibbles expose any nibble or byte swapped out of order. Random runs of wait nibbles, including a code the block does not know, test that the sync loop keeps sampling. Directed cases cover an error sync, a sync that never arrives, and a request raised in the middle of a cycle; these tell the fault path, the abort path and the idle-only acceptance apart.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int NIB_W  = 4;

   typedef enum logic [1:0] {
      K_IO  = 2'd0,
      K_MEM = 2'd1,
      K_FW  = 2'd2,
      K_DMA = 2'd3
   } kind_e;

   typedef enum logic [3:0] {
      S_IDLE, S_START, S_CTYPE, S_ADDR, S_CHAN, S_SIZE, S_HDATA,
      S_HTAR1, S_HTAR2, S_SYNC, S_PDATA, S_PTAR1, S_PTAR2, S_ABORT, S_DONE
   } state_e;

   localparam logic [3:0] ST_STD      = 4'h0;
   localparam logic [3:0] ST_FW_RD    = 4'hD;
   localparam logic [3:0] ST_FW_WR    = 4'hE;
   localparam logic [3:0] SY_READY    = 4'h0;
   localparam logic [3:0] SY_FAULT    = 4'hA;
   localparam logic [3:0] NIB_ONES    = 4'hF;

   // index of the last data nibble of a transfer
   function automatic logic [3:0] last_nibble(kind_e k, logic [1:0] sz);
      if (k == K_IO || k == K_MEM) return 4'd1;
      case (sz)
         2'd0:    return 4'd1;
         2'd1:    return 4'd3;
         default: return 4'd7;
      endcase
   endfunction

   // size nibble: DMA and firmware differ only in the four-byte code
   function automatic logic [3:0] size_nibble(kind_e k, logic [1:0] sz);
      case (sz)
         2'd0:    return 4'h0;
         2'd1:    return 4'h1;
         default: return (k == K_DMA) ? 4'h3 : 4'h2;
      endcase
   endfunction

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
   import lpc_host_pkg::*;
(
   input  logic [NIB_W-1:0] nib,
   output logic             is_ready,
   output logic             is_fault
);
   // every other code, named wait codes included, means keep waiting
   always_comb begin
      is_ready = (nib == SY_READY);
      is_fault = (nib == SY_FAULT);
   end
endmodule

// File: rtl/lpc_sync_timer.sv
module lpc_sync_timer #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("lpc_sync_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (!expire) cnt <= cnt + 1'b1;
   end

   assign expire = run && (cnt == CW'(LIMIT - 1));

   // R10: the count never passes the window
   p_window_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (int'(cnt) < LIMIT));

endmodule

// File: rtl/lpc_host_fsm.sv
module lpc_host_fsm
   import lpc_host_pkg::*;
#(
   parameter int ABORT_CLKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_dma_tc,
   input  logic [2:0]        req_dma_chan,
   input  logic [NIB_W-1:0]  lad_in,
   input  logic              sync_ready,
   input  logic              sync_fault,
   input  logic              tmo_expire,
   output logic              in_sync,
   output logic              req_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              rsp_timeout,
   output logic              frame_n,
   output logic [NIB_W-1:0]  lad_out,
   output logic              lad_oe
);
   localparam int AB_W = $clog2(ABORT_CLKS + 1);

   state_e            state;
   kind_e             kind;
   logic              wr;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W-1:0] rdata;
   logic              tc;
   logic [2:0]        chan;
   logic [1:0]        szc;
   logic [3:0]        last;
   logic [2:0]        aidx;
   logic [3:0]        didx;
   logic [AB_W-1:0]   ab_cnt;
   logic              err_f;
   logic              tmo_f;

   wire is_dma = (kind == K_DMA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         kind   <= K_IO;
         wr     <= 1'b0;
         addr   <= '0;
         wdata  <= '0;
         rdata  <= '0;
         tc     <= 1'b0;
         chan   <= '0;
         szc    <= '0;
         last   <= '0;
         aidx   <= '0;
         didx   <= '0;
         ab_cnt <= '0;
         err_f  <= 1'b0;
         tmo_f  <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (req_valid) begin
               kind   <= kind_e'(req_kind);
               wr     <= req_write;
               addr   <= req_addr;
               wdata  <= req_wdata;
               tc     <= req_dma_tc;
               chan   <= req_dma_chan;
               szc    <= req_size;
               last   <= last_nibble(kind_e'(req_kind), req_size);
               aidx   <= (kind_e'(req_kind) == K_IO) ? 3'd3 : 3'd7;
               didx   <= '0;
               rdata  <= '0;
               err_f  <= 1'b0;
               tmo_f  <= 1'b0;
               state  <= S_START;
            end
            S_START: state <= (kind == K_FW) ? S_ADDR : S_CTYPE;
            S_CTYPE: state <= is_dma ? S_CHAN : S_ADDR;
            S_ADDR: begin
               if (aidx == 3'd0) begin
                  if (kind == K_FW) state <= S_SIZE;
                  else              state <= wr ? S_HDATA : S_HTAR1;
               end else begin
                  aidx <= aidx - 3'd1;
               end
            end
            S_CHAN: state <= S_SIZE;
            S_SIZE: state <= wr ? S_HDATA : S_HTAR1;
            S_HDATA: begin
               didx <= didx + 4'd1;
               if (is_dma ? didx[0] : (didx == last)) state <= S_HTAR1;
            end
            S_HTAR1: state <= S_HTAR2;
            S_HTAR2: state <= S_SYNC;
            S_SYNC: begin
               if (sync_ready) begin
                  state <= wr ? S_PTAR1 : S_PDATA;
               end else if (sync_fault) begin
                  err_f <= 1'b1;
                  state <= S_PTAR1;
               end else if (tmo_expire) begin
                  tmo_f  <= 1'b1;
                  ab_cnt <= '0;
                  state  <= S_ABORT;
               end
            end
            S_PDATA: begin
               rdata[{didx[2:0], 2'b00} +: NIB_W] <= lad_in;
               didx <= didx + 4'd1;
               if (didx == last)             state <= S_PTAR1;
               else if (is_dma && didx[0])   state <= S_SYNC;
            end
            S_PTAR1: state <= S_PTAR2;
            S_PTAR2: begin
               if (!err_f && is_dma && wr && (didx != 4'(last + 4'd1)))
                  state <= S_HDATA;
               else
                  state <= S_DONE;
            end
            S_ABORT: begin
               if (ab_cnt == AB_W'(ABORT_CLKS - 1)) state <= S_DONE;
               else                                 ab_cnt <= ab_cnt + 1'b1;
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   // bus outputs are a pure decode of the current state
   always_comb begin
      frame_n = 1'b1;
      lad_oe  = 1'b0;
      lad_out = NIB_ONES;
      case (state)
         S_START: begin
            frame_n = 1'b0;
            lad_oe  = 1'b1;
            if (kind == K_FW) lad_out = wr ? ST_FW_WR : ST_FW_RD;
            else              lad_out = ST_STD;
         end
         S_CTYPE: begin
            lad_oe  = 1'b1;
            lad_out = {is_dma, kind == K_MEM, is_dma ? ~wr : wr, 1'b0};
         end
         S_ADDR: begin
            lad_oe  = 1'b1;
            lad_out = addr[{aidx, 2'b00} +: NIB_W];
         end
         S_CHAN: begin
            lad_oe  = 1'b1;
            lad_out = {tc, chan};
         end
         S_SIZE: begin
            lad_oe  = 1'b1;
            lad_out = size_nibble(kind, szc);
         end
         S_HDATA: begin
            lad_oe  = 1'b1;
            lad_out = wdata[{didx[2:0], 2'b00} +: NIB_W];
         end
         S_HTAR1: lad_oe = 1'b1;
         S_ABORT: begin
            frame_n = 1'b0;
            lad_oe  = 1'b1;
         end
         default: ;
      endcase
   end

   assign in_sync     = (state == S_SYNC);
   assign req_ack     = (state == S_DONE);
   assign rsp_rdata   = rdata;
   assign rsp_err     = err_f;
   assign rsp_timeout = tmo_f;

   // R2: the host owns LAD whenever the frame strobe is low
   p_frame_owns_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |-> lad_oe);

   // R2: a falling frame strobe carries a start or an abort nibble
   p_start_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n) |-> (lad_out == ST_STD || lad_out == ST_FW_RD ||
                          lad_out == ST_FW_WR || lad_out == NIB_ONES));

   // R7: the host only lets go of LAD after a clock of all ones
   p_release_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lad_oe) |-> ($past(lad_out) == NIB_ONES));

   // R8: a wait code inside the window keeps the host sampling
   p_wait_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && !sync_ready && !sync_fault && !tmo_expire) |=> in_sync);

   // R9: an error sync raises the fault flag
   p_fault_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && sync_fault) |=> rsp_err);

   // R12: the acknowledge is a single-clock pulse
   p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

endmodule

// File: rtl/lpc_host_cycle_gen.sv
module lpc_host_cycle_gen
   import lpc_host_pkg::*;
#(
   parameter int TMO_CLKS   = 64,
   parameter int ABORT_CLKS = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [1:0]  req_kind,
   input  logic        req_write,
   input  logic [31:0] req_addr,
   input  logic [1:0]  req_size,
   input  logic [31:0] req_wdata,
   input  logic        req_dma_tc,
   input  logic [2:0]  req_dma_chan,
   output logic        req_ack,
   output logic [31:0] rsp_rdata,
   output logic        rsp_err,
   output logic        rsp_timeout,
   output logic        frame_n,
   output logic [3:0]  lad_out,
   output logic        lad_oe,
   input  logic [3:0]  lad_in
);
   generate
      if (ABORT_CLKS < 1 || ABORT_CLKS > 15) begin : g_bad_abort
         $error("lpc_host_cycle_gen: ABORT_CLKS out of range");
      end
   endgenerate

   logic sync_ready;
   logic sync_fault;
   logic tmo_expire;
   logic in_sync;

   lpc_sync_decode u_dec (
      .nib      (lad_in),
      .is_ready (sync_ready),
      .is_fault (sync_fault)
   );

   lpc_sync_timer #(.LIMIT(TMO_CLKS)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (in_sync),
      .expire (tmo_expire)
   );

   lpc_host_fsm #(.ABORT_CLKS(ABORT_CLKS)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_kind     (req_kind),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .req_size     (req_size),
      .req_wdata    (req_wdata),
      .req_dma_tc   (req_dma_tc),
      .req_dma_chan (req_dma_chan),
      .lad_in       (lad_in),
      .sync_ready   (sync_ready),
      .sync_fault   (sync_fault),
      .tmo_expire   (tmo_expire),
      .in_sync      (in_sync),
      .req_ack      (req_ack),
      .rsp_rdata    (rsp_rdata),
      .rsp_err      (rsp_err),
      .rsp_timeout  (rsp_timeout),
      .frame_n      (frame_n),
      .lad_out      (lad_out),
      .lad_oe       (lad_oe)
   );

   // R10: a timeout acknowledge comes straight after an abort clock
   p_abort_before_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ack && rsp_timeout) |-> $past(!frame_n));

endmodule

// File: tb/lpc_host_cycle_gen_test.sv
module lpc_host_cycle_gen_test;
   localparam int TMO = 10;
   localparam int ABT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        req_dma_tc = 1'b0;
   logic [2:0]  req_dma_chan = '0;
   logic [3:0]  lad_in = 4'hF;
   logic        req_ack;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic        rsp_timeout;
   logic        frame_n;
   logic [3:0]  lad_out;
   logic        lad_oe;

   always #4 clk = ~clk;

   lpc_host_cycle_gen #(.TMO_CLKS(TMO), .ABORT_CLKS(ABT)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .req_dma_tc(req_dma_tc), .req_dma_chan(req_dma_chan),
      .req_ack(req_ack), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .rsp_timeout(rsp_timeout), .frame_n(frame_n), .lad_out(lad_out),
      .lad_oe(lad_oe), .lad_in(lad_in)
   );

   int checks = 0;
   int errors = 0;

   logic       e_frm [256];
   logic       e_oe  [256];
   logic [3:0] e_nib [256];
   logic [3:0] e_in  [256];
   string      e_tag [256];
   int         ne;
   logic [31:0] x_rdata;
   logic        x_err;
   logic        x_tmo;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic push(logic f, logic o, logic [3:0] n, logic [3:0] i, string t);
      e_frm[ne] = f; e_oe[ne] = o; e_nib[ne] = n; e_in[ne] = i; e_tag[ne] = t;
      ne++;
   endtask

   function automatic int nbytes(int k, int sz);
      if (k < 2) return 1;
      return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
   endfunction

   function automatic logic [3:0] wait_code(int w);
      case (w % 3)
         0:       return 4'h5;
         1:       return 4'h6;
         default: return 4'h3;   // unnamed code, treated as wait (R8)
      endcase
   endfunction

   // peripheral sync phase; stop=1 when the cycle ends inside it
   task automatic add_sync(int waits, int mode, output bit stop);
      stop = 1'b0;
      if (mode == 2) begin
         for (int t = 0; t < TMO; t++) push(1, 0, 4'hF, 4'h5, "R10");
         for (int a = 0; a < ABT; a++) push(0, 1, 4'hF, 4'hF, "R10");
         x_tmo = 1'b1;
         stop = 1'b1;
      end else begin
         for (int w = 0; w < waits; w++) push(1, 0, 4'hF, wait_code(w), "R8");
         if (mode == 1) begin
            push(1, 0, 4'hF, 4'hA, "R9");
            push(1, 0, 4'hF, 4'hF, "R9");
            push(1, 0, 4'hF, 4'hF, "R9");
            x_err = 1'b1;
            stop = 1'b1;
         end else begin
            push(1, 0, 4'hF, 4'h0, "R8");
         end
      end
   endtask

   task automatic build(int k, bit wr, logic [31:0] addr, int sz, logic [31:0] wdata,
                        logic [31:0] rdat, bit tc, logic [2:0] chan, int waits, int mode);
      int  n;
      bit  stop;
      logic [3:0] sc;
      ne = 0; x_err = 1'b0; x_tmo = 1'b0; x_rdata = '0;
      n = nbytes(k, sz);
      sc = (k == 2) ? (wr ? 4'hE : 4'hD) : 4'h0;
      push(0, 1, sc, 4'hF, "R2");
      if (k != 2) push(1, 1, {k == 3, k == 1, (k == 3) ? !wr : wr, 1'b0}, 4'hF, "R3");
      if (k != 3) begin
         for (int i = ((k == 0) ? 3 : 7); i >= 0; i--) push(1, 1, addr[4*i +: 4], 4'hF, "R4");
      end else begin
         push(1, 1, {tc, chan}, 4'hF, "R5");
         push(1, 1, (n == 1) ? 4'h0 : (n == 2) ? 4'h1 : 4'h3, 4'hF, "R5");
      end
      if (k == 2) push(1, 1, (n == 1) ? 4'h0 : (n == 2) ? 4'h1 : 4'h2, 4'hF, "R5");
      if (wr) begin
         if (k == 3) begin
            for (int b = 0; b < n; b++) begin
               push(1, 1, wdata[8*b +: 4], 4'hF, "R11");
               push(1, 1, wdata[8*b+4 +: 4], 4'hF, "R11");
               push(1, 1, 4'hF, 4'hF, "R7");
               push(1, 0, 4'hF, 4'hF, "R7");
               add_sync(waits, mode, stop);
               if (stop) return;
               push(1, 0, 4'hF, 4'hF, "R7");
               push(1, 0, 4'hF, 4'hF, "R7");
            end
         end else begin
            for (int j = 0; j < 2*n; j++) push(1, 1, wdata[4*j +: 4], 4'hF, "R6");
            push(1, 1, 4'hF, 4'hF, "R7");
            push(1, 0, 4'hF, 4'hF, "R7");
            add_sync(waits, mode, stop);
            if (stop) return;
            push(1, 0, 4'hF, 4'hF, "R7");
            push(1, 0, 4'hF, 4'hF, "R7");
         end
      end else begin
         push(1, 1, 4'hF, 4'hF, "R7");
         push(1, 0, 4'hF, 4'hF, "R7");
         if (k == 3) begin
            for (int b = 0; b < n; b++) begin
               add_sync(waits, mode, stop);
               if (stop) return;
               push(1, 0, 4'hF, rdat[8*b +: 4], "R11");
               push(1, 0, 4'hF, rdat[8*b+4 +: 4], "R11");
            end
         end else begin
            add_sync(waits, mode, stop);
            if (stop) return;
            for (int j = 0; j < 2*n; j++) push(1, 0, 4'hF, rdat[4*j +: 4], "R6");
         end
         push(1, 0, 4'hF, 4'hF, "R7");
         push(1, 0, 4'hF, 4'hF, "R7");
         for (int j = 0; j < 8*n; j++) x_rdata[j] = rdat[j];
      end
   endtask

   task automatic run(int k, bit wr, logic [31:0] addr, int sz, logic [31:0] wdata,
                      logic [31:0] rdat, bit tc, logic [2:0] chan, int waits, int mode,
                      bit noise);
      build(k, wr, addr, sz, wdata, rdat, tc, chan, waits, mode);
      @(negedge clk);
      req_kind = 2'(k); req_write = wr; req_addr = addr; req_size = 2'(sz);
      req_wdata = wdata; req_dma_tc = tc; req_dma_chan = chan; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < ne; i++) begin
         chk(e_tag[i], "frame_n", {31'b0, frame_n}, {31'b0, e_frm[i]});
         chk(e_tag[i], "lad_oe", {31'b0, lad_oe}, {31'b0, e_oe[i]});
         if (e_oe[i]) chk(e_tag[i], "lad_out", {28'b0, lad_out}, {28'b0, e_nib[i]});
         lad_in = e_in[i];
         if (noise && i == 2) begin
            req_valid = 1'b1; req_kind = 2'(k ^ 1); req_addr = ~addr;
            req_write = !wr; req_wdata = ~wdata;
         end
         if (noise && i == 3) req_valid = 1'b0;
         @(negedge clk);
      end
      lad_in = 4'hF;
      chk("R12", "ack", {31'b0, req_ack}, 32'd1);
      chk("R9", "err", {31'b0, rsp_err}, {31'b0, x_err});
      chk("R10", "timeout", {31'b0, rsp_timeout}, {31'b0, x_tmo});
      if (!x_err && !x_tmo) chk((k == 3) ? "R11" : "R6", "rdata", rsp_rdata, x_rdata);
      @(negedge clk);
      chk("R12", "ack_drop", {31'b0, req_ack}, 32'd0);
      if (noise) begin
         for (int c = 0; c < 3; c++) begin
            chk("R12", "stays_idle", {31'b0, frame_n}, 32'd1);
            @(negedge clk);
         end
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R1", "frame_n_rst", {31'b0, frame_n}, 32'd1);
      chk("R1", "lad_oe_rst", {31'b0, lad_oe}, 32'd0);
      chk("R1", "ack_rst", {31'b0, req_ack}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "frame_n_idle", {31'b0, frame_n}, 32'd1);

      // directed: each kind and direction, distinct nibbles
      run(0, 1, 32'h0000_1234, 0, 32'h0000_00A5, 32'h0, 0, 3'd0, 0, 0, 0);   // R4 I/O write
      run(0, 0, 32'hFFFF_BEEF, 0, 32'h0,         32'hC3C3_C35A, 0, 3'd0, 2, 0, 0);
      run(1, 1, 32'h89AB_CDEF, 2, 32'h0000_0017, 32'h0, 0, 3'd0, 1, 0, 0);
      run(1, 0, 32'h0123_4567, 0, 32'h0,         32'h0000_00E4, 0, 3'd0, 3, 0, 0);
      run(2, 0, 32'hFEDC_BA98, 2, 32'h0,         32'h7654_3210, 0, 3'd0, 1, 0, 0);   // R5 fw 4B
      run(2, 1, 32'h1357_9BDF, 1, 32'h0000_C0DE, 32'h0, 0, 3'd0, 0, 0, 0);
      run(3, 1, 32'h0,         3, 32'h4433_2211, 32'h0, 1, 3'd5, 2, 0, 0);       // R11 dma write
      run(3, 0, 32'h0,         1, 32'h0,         32'h0000_9A8B, 0, 3'd2, 4, 0, 0); // R11 dma read
      // R9 error sync, R10 timeout, R12 request while busy
      run(1, 0, 32'h1111_2222, 0, 32'h0,         32'h0000_0055, 0, 3'd0, 1, 1, 0);
      run(3, 1, 32'h0,         2, 32'h1234_5678, 32'h0, 0, 3'd1, 0, 1, 0);
      run(0, 0, 32'h0000_0080, 0, 32'h0,         32'h0, 0, 3'd0, 0, 2, 0);
      run(3, 0, 32'h0,         2, 32'h0,         32'h0, 1, 3'd7, 0, 2, 0);
      run(2, 1, 32'hAAAA_5555, 2, 32'hCAFE_F00D, 32'h0, 0, 3'd0, 2, 0, 1);

      for (int t = 0; t < 60; t++) begin
         int k, sz, waits, mode;
         k = int'($urandom % 4);
         sz = int'($urandom % 4);
         waits = int'($urandom % 4);
         mode = (($urandom % 10) == 0) ? 1 : 0;
         run(k, 1'($urandom % 2), $urandom, sz, $urandom, $urandom,
             1'($urandom % 2), 3'($urandom % 8), waits, mode, 1'($urandom % 8 == 0));
      end

      summary();
      $finish;
   end
endmodule